// File: doc/BRIEF.md
# DDR3 Command Bus Decoder

This block watches the command pins of a DDR3 memory bus and, on every rising clock edge, turns the pins into one decoded command. It takes the clock-enable level from the previous edge and from the present edge, the chip select and the three strobe lines (row, column and write, all active low), the bank address, and the two address bits that choose sub-variants. The block looks at the pair of clock-enable levels first. Commands that move the device into or out of a low-power state are told apart from normal commands in this way. After that, it uses address bit 10 and address bit 12 to separate the command variants. A mode input says whether the burst length is chosen per command or comes from the fixed mode-register setting.

The decoded result appears one clock after the pins are sampled, through a single register stage. This makes the block suitable for a bus monitor, a protocol checker, or the front end of a memory model. There is no valid/ready handshake at either edge and so no back-pressure. The pins are taken on every edge, and a fresh result comes out every cycle without a stall. A consumer that cannot keep up must buffer the results itself. An active-low asynchronous reset forces the outputs to the deselect state.

Command codes on `cmd_o`:

| Code | Command |
|---|---|
| 0 | deselect |
| 1 | no operation |
| 2 | mode register set |
| 3 | refresh |
| 4 | activate |
| 5 | precharge one bank |
| 6 | precharge all banks |
| 7 | write |
| 8 | read |
| 9 | ZQ calibration, long |
| 10 | ZQ calibration, short |
| 11 | self-refresh entry |
| 12 | power-down entry |
| 13 | low-power exit |
| 14 | low-power hold |

Burst codes on `burst_o`: 0 = fixed (mode register), 1 = chop 4, 2 = length 8.

Top module: `ddr3_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, every output is cleared, whatever the pins are: `cmd_o`=0 (deselect), `autopre_o`=0, `burst_o`=0, `bank_o`=0, `illegal_o`=0.
- R2: Each edge's decode appears on the outputs exactly one cycle later. With clock enable high at both edges and chip select high, `cmd_o` is 0 (deselect) whatever the other pins are.
- R3: With clock enable high at both edges and chip select low, the strobes {row, column, write} decode as follows:
  - 000 gives `cmd_o`=2 (mode register set).
  - 001 gives 3 (refresh).
  - 011 gives 4 (activate).
  - 111 gives 1 (no operation).
- R4: With clock enable high at both edges, chip select low and strobes 010, the command is a precharge. Address bit 10 low gives `cmd_o`=5 (one bank). Address bit 10 high gives 6 (all banks).
- R5: With clock enable high at both edges and chip select low, strobes 100 give `cmd_o`=7 (write) and strobes 101 give 8 (read). On these two, `autopre_o` equals address bit 10. On every other command `autopre_o` is 0.
- R6: On a read or write, the burst code depends on the mode input `otf_en_i`:
  - With `otf_en_i` high, address bit 12 low gives `burst_o`=1 (chop 4) and high gives 2 (length 8).
  - With `otf_en_i` low, `burst_o` is 0 (fixed) and address bit 12 has no effect.
  - On every other command `burst_o` is 0.
- R7: With clock enable high at both edges, chip select low and strobes 110, the command is a ZQ calibration. Address bit 10 high gives `cmd_o`=9 (long). Address bit 10 low gives 10 (short).
- R8: With clock enable high then low, a refresh pin pattern gives `cmd_o`=11 (self-refresh entry). A no-operation or deselect pin pattern gives 12 (power-down entry).
- R9: With clock enable low then high, a no-operation or deselect pin pattern gives `cmd_o`=13 (low-power exit).
- R10: With clock enable low at both edges, `cmd_o` is 14 (low-power hold) whatever the other pins are, and `illegal_o` is 0.
- R11: Any other pin pattern during a clock-enable transition sets the following:
  - `illegal_o`=1 and `cmd_o`=1 (no operation).
  - `autopre_o`=0, `burst_o`=0 and `bank_o`=0.
- R12: `bank_o` carries the bank address for mode register set, activate, single-bank precharge, read and write. It is 0 for every other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock, rising edge samples the pins |
| rst_n | input | 1 | asynchronous active-low reset |
| cke_prev_i | input | 1 | clock-enable level at the previous edge |
| cke_i | input | 1 | clock-enable level at the present edge |
| cs_n_i | input | 1 | chip select, active low |
| ras_n_i | input | 1 | row strobe, active low |
| cas_n_i | input | 1 | column strobe, active low |
| we_n_i | input | 1 | write strobe, active low |
| ba_i | input | BA_W | bank address |
| a10_i | input | 1 | address bit 10: auto-precharge, all-bank or long-ZQ select |
| a12_i | input | 1 | address bit 12: per-command burst select |
| otf_en_i | input | 1 | mode: per-command burst selection enabled |
| cmd_o | output | 4 | decoded command code |
| autopre_o | output | 1 | read or write with auto-precharge |
| burst_o | output | 2 | burst code |
| bank_o | output | BA_W | bank number of the command |
| illegal_o | output | 1 | pin pattern not a legal command |

## Verification
Some behaviours are checked by the assertions on every cycle:
- Deselect whenever clock enable stays high and chip select is high.
- The low-power hold while clock enable stays low, with the illegal flag clear.
- Self-refresh entry on a falling clock enable with the refresh pattern.
- Fixed burst whenever the per-command mode is off.
- Auto-precharge appearing only on reads and writes.
- The no-operation form that every illegal result takes, with its side outputs cleared.

Other behaviours only the bench scenarios can show:
- The exact code for each of the strobe patterns.
- The address-bit sub-variants.
- The bank forwarding, and the zeroing of the bank on commands that do not name one.
- The reset clearing outputs that held live values.

// File: rtl/ddr3_dec_pkg.sv
package ddr3_dec_pkg;

  localparam int CMD_W = 4;
  localparam int BST_W = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_REF   = 4'd3,
    CMD_ACT   = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_PREA  = 4'd6,
    CMD_WR    = 4'd7,
    CMD_RD    = 4'd8,
    CMD_ZQL   = 4'd9,
    CMD_ZQS   = 4'd10,
    CMD_SRE   = 4'd11,
    CMD_PDE   = 4'd12,
    CMD_WAKE  = 4'd13,
    CMD_HOLD  = 4'd14
  } cmd_e;

  typedef enum logic [BST_W-1:0] {
    BST_FIXED = 2'd0,
    BST_BC4   = 2'd1,
    BST_BL8   = 2'd2
  } burst_e;

  // Pin-level class before clock-enable context is applied
  typedef enum logic [3:0] {
    OP_MRS,
    OP_REF,
    OP_PRE,
    OP_ACT,
    OP_WR,
    OP_RD,
    OP_ZQ,
    OP_NOP,
    OP_DES
  } op_e;

  // {previous, present} clock-enable pair
  typedef enum logic [1:0] {
    CK_HOLD  = 2'b00,
    CK_WAKE  = 2'b01,
    CK_SLEEP = 2'b10,
    CK_RUN   = 2'b11
  } cke_e;

  function automatic logic carries_bank(input cmd_e c);
    return (c == CMD_MRS) || (c == CMD_ACT) || (c == CMD_PRE) ||
           (c == CMD_WR)  || (c == CMD_RD);
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_WR) || (c == CMD_RD);
  endfunction

endpackage

// File: rtl/ddr3_pin_class.sv
module ddr3_pin_class
  import ddr3_dec_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_e  op
);

  always_comb begin
    if (cs_n) begin
      op = OP_DES;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  op = OP_MRS;
        3'b001:  op = OP_REF;
        3'b010:  op = OP_PRE;
        3'b011:  op = OP_ACT;
        3'b100:  op = OP_WR;
        3'b101:  op = OP_RD;
        3'b110:  op = OP_ZQ;
        default: op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr3_cke_resolve.sv
module ddr3_cke_resolve
  import ddr3_dec_pkg::*;
(
  input  logic cke_prev,
  input  logic cke_now,
  input  op_e  op,
  input  logic a10,
  output cmd_e cmd,
  output logic illegal
);

  cke_e phase;
  assign phase = cke_e'({cke_prev, cke_now});

  always_comb begin
    cmd     = CMD_NOP;
    illegal = 1'b0;
    unique case (phase)
      CK_RUN: begin
        unique case (op)
          OP_DES:  cmd = CMD_DESEL;
          OP_NOP:  cmd = CMD_NOP;
          OP_MRS:  cmd = CMD_MRS;
          OP_REF:  cmd = CMD_REF;
          OP_ACT:  cmd = CMD_ACT;
          OP_PRE:  cmd = a10 ? CMD_PREA : CMD_PRE;
          OP_WR:   cmd = CMD_WR;
          OP_RD:   cmd = CMD_RD;
          OP_ZQ:   cmd = a10 ? CMD_ZQL : CMD_ZQS;
          default: cmd = CMD_NOP;
        endcase
      end
      CK_SLEEP: begin
        if (op == OP_REF) begin
          cmd = CMD_SRE;
        end else if ((op == OP_NOP) || (op == OP_DES)) begin
          cmd = CMD_PDE;
        end else begin
          illegal = 1'b1;
        end
      end
      CK_WAKE: begin
        if ((op == OP_NOP) || (op == OP_DES)) begin
          cmd = CMD_WAKE;
        end else begin
          illegal = 1'b1;
        end
      end
      default: cmd = CMD_HOLD;
    endcase
  end

endmodule

// File: rtl/ddr3_field_pick.sv
module ddr3_field_pick
  import ddr3_dec_pkg::*;
#(
  parameter int BA_W = 3
) (
  input  cmd_e            cmd,
  input  logic            illegal,
  input  logic            a10,
  input  logic            a12,
  input  logic            otf_en,
  input  logic [BA_W-1:0] ba,
  output logic            autopre,
  output burst_e          burst,
  output logic [BA_W-1:0] bank
);

  logic access;
  assign access = is_access(cmd) && !illegal;

  always_comb begin
    autopre = access && a10;
    if (!access || !otf_en) begin
      burst = BST_FIXED;
    end else begin
      burst = a12 ? BST_BL8 : BST_BC4;
    end
  end

  // Bank lanes: each bit is gated by whether the command names a bank
  logic keep_bank;
  assign keep_bank = carries_bank(cmd) && !illegal;

  for (genvar gi = 0; gi < BA_W; gi++) begin : g_bank
    assign bank[gi] = ba[gi] & keep_bank;
  end

endmodule

// File: rtl/ddr3_cmd_decoder.sv
module ddr3_cmd_decoder
  import ddr3_dec_pkg::*;
#(
  parameter int BA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke_prev_i,
  input  logic            cke_i,
  input  logic            cs_n_i,
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  input  logic            a12_i,
  input  logic            otf_en_i,
  output logic [3:0]      cmd_o,
  output logic            autopre_o,
  output logic [1:0]      burst_o,
  output logic [BA_W-1:0] bank_o,
  output logic            illegal_o
);

  op_e             op_w;
  cmd_e            cmd_w;
  logic            ill_w;
  logic            ap_w;
  burst_e          bst_w;
  logic [BA_W-1:0] bank_w;

  ddr3_pin_class u_class (
    .cs_n  (cs_n_i),
    .ras_n (ras_n_i),
    .cas_n (cas_n_i),
    .we_n  (we_n_i),
    .op    (op_w)
  );

  ddr3_cke_resolve u_resolve (
    .cke_prev (cke_prev_i),
    .cke_now  (cke_i),
    .op       (op_w),
    .a10      (a10_i),
    .cmd      (cmd_w),
    .illegal  (ill_w)
  );

  ddr3_field_pick #(.BA_W(BA_W)) u_fields (
    .cmd     (cmd_w),
    .illegal (ill_w),
    .a10     (a10_i),
    .a12     (a12_i),
    .otf_en  (otf_en_i),
    .ba      (ba_i),
    .autopre (ap_w),
    .burst   (bst_w),
    .bank    (bank_w)
  );

  cmd_e            cmd_q;
  logic            ap_q;
  burst_e          bst_q;
  logic [BA_W-1:0] bank_q;
  logic            ill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DESEL;
      ap_q   <= 1'b0;
      bst_q  <= BST_FIXED;
      bank_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_w;
      ap_q   <= ap_w;
      bst_q  <= bst_w;
      bank_q <= bank_w;
      ill_q  <= ill_w;
    end
  end

  assign cmd_o     = cmd_q;
  assign autopre_o = ap_q;
  assign burst_o   = bst_q;
  assign bank_o    = bank_q;
  assign illegal_o = ill_q;

  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_prev_i && cke_i && cs_n_i) |=> (cmd_o == CMD_DESEL));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_prev_i && !cke_i) |=> (cmd_o == CMD_HOLD && !illegal_o));

  p_sre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_prev_i && !cke_i && !cs_n_i && !ras_n_i && !cas_n_i && we_n_i)
      |=> (cmd_o == CMD_SRE));

  p_fixed_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !otf_en_i |=> (burst_o == BST_FIXED));

  p_autopre_rw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    autopre_o |-> (cmd_o == CMD_WR || cmd_o == CMD_RD));

  p_illegal_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (cmd_o == CMD_NOP && !autopre_o && burst_o == BST_FIXED &&
                   bank_o == '0));

endmodule

// File: tb/tb_ddr3_cmd_decoder.sv
module tb_ddr3_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int BA_W       = 3;
  localparam int EXP_W      = 4 + 1 + 2 + BA_W + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cke_prev_i = 1'b1, cke_i = 1'b1;
  logic            cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [BA_W-1:0] ba_i = '0;
  logic            a10_i = 1'b0, a12_i = 1'b0, otf_en_i = 1'b0;
  logic [3:0]      cmd_o;
  logic            autopre_o;
  logic [1:0]      burst_o;
  logic [BA_W-1:0] bank_o;
  logic            illegal_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [EXP_W-1:0] exp_q[$];
  string            tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr3_cmd_decoder #(.BA_W(BA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cke_prev_i(cke_prev_i), .cke_i(cke_i),
    .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .ba_i(ba_i), .a10_i(a10_i), .a12_i(a12_i), .otf_en_i(otf_en_i),
    .cmd_o(cmd_o), .autopre_o(autopre_o), .burst_o(burst_o),
    .bank_o(bank_o), .illegal_o(illegal_o)
  );

  function automatic logic [EXP_W-1:0] pack_out(
    input logic [3:0] c, input logic ap, input logic [1:0] b,
    input logic [BA_W-1:0] bk, input logic il);
    return {il, ap, b, bk, c};
  endfunction

  task automatic compare(input logic [EXP_W-1:0] exp, input string tag);
    logic [EXP_W-1:0] got;
    got = pack_out(cmd_o, autopre_o, burst_o, bank_o, illegal_o);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got cmd=%0d ap=%0d burst=%0d bank=%0d ill=%0d, expected cmd=%0d ap=%0d burst=%0d bank=%0d ill=%0d",
               tag, got[3:0], got[EXP_W-2], got[EXP_W-3 -: 2], got[4 +: BA_W],
               got[EXP_W-1], exp[3:0], exp[EXP_W-2], exp[EXP_W-3 -: 2],
               exp[4 +: BA_W], exp[EXP_W-1]);
    end
  endtask

  // Driver: one pin pattern per cycle, expected result pushed to the scoreboard
  task automatic drv(
    input logic cp, input logic cn, input logic cs, input logic r,
    input logic c, input logic w, input logic [BA_W-1:0] ba,
    input logic a10, input logic a12, input logic otf,
    input logic [3:0] ecmd, input logic eap, input logic [1:0] ebst,
    input logic [BA_W-1:0] ebank, input logic eill, input string tag);
    @(negedge clk);
    cke_prev_i = cp; cke_i = cn; cs_n_i = cs;
    ras_n_i = r; cas_n_i = c; we_n_i = w;
    ba_i = ba; a10_i = a10; a12_i = a12; otf_en_i = otf;
    exp_q.push_back(pack_out(ecmd, eap, ebst, ebank, eill));
    tag_q.push_back(tag);
  endtask

  // Monitor: results are registered one edge after the pattern
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [EXP_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compare(e, t);
      end
    end
  end

  initial begin
    // R1: reset holds outputs clear while a mode-register pattern is driven
    cke_prev_i = 1; cke_i = 1; cs_n_i = 0; ras_n_i = 0; cas_n_i = 0; we_n_i = 0;
    ba_i = 3'd5; a10_i = 1; a12_i = 1; otf_en_i = 1;
    repeat (3) @(negedge clk);
    compare(pack_out(4'd0, 0, 2'd0, 3'd0, 0), "R1 reset");
    rst_n = 1'b1;

    // R2: deselect whatever the strobes say
    drv(1,1,1, 0,1,0, 3'd7, 1,1,1, 4'd0,0,2'd0,3'd0,0, "R2 deselect a");
    drv(1,1,1, 0,0,0, 3'd2, 0,0,0, 4'd0,0,2'd0,3'd0,0, "R2 deselect b");
    // R3 / R12
    drv(1,1,0, 0,0,0, 3'd5, 0,1,1, 4'd2,0,2'd0,3'd5,0, "R3 R12 mrs");
    drv(1,1,0, 0,0,1, 3'd6, 1,1,1, 4'd3,0,2'd0,3'd0,0, "R3 R12 refresh");
    drv(1,1,0, 0,1,1, 3'd3, 1,0,0, 4'd4,0,2'd0,3'd3,0, "R3 activate");
    drv(1,1,0, 1,1,1, 3'd4, 0,0,0, 4'd1,0,2'd0,3'd0,0, "R3 nop");
    // R4
    drv(1,1,0, 0,1,0, 3'd6, 0,0,0, 4'd5,0,2'd0,3'd6,0, "R4 precharge one");
    drv(1,1,0, 0,1,0, 3'd6, 1,0,0, 4'd6,0,2'd0,3'd0,0, "R4 R12 precharge all");
    // R5 / R6
    drv(1,1,0, 1,0,0, 3'd1, 0,1,0, 4'd7,0,2'd0,3'd1,0, "R5 R6 write fixed, a12 ignored");
    drv(1,1,0, 1,0,0, 3'd2, 1,0,1, 4'd7,1,2'd1,3'd2,0, "R5 R6 write ap bc4");
    drv(1,1,0, 1,0,1, 3'd7, 0,1,1, 4'd8,0,2'd2,3'd7,0, "R5 R6 read bl8");
    drv(1,1,0, 1,0,1, 3'd4, 1,0,0, 4'd8,1,2'd0,3'd4,0, "R5 R6 read ap fixed");
    // R7
    drv(1,1,0, 1,1,0, 3'd3, 1,1,1, 4'd9,0,2'd0,3'd0,0, "R7 R6 zq long");
    drv(1,1,0, 1,1,0, 3'd3, 0,0,1, 4'd10,0,2'd0,3'd0,0, "R7 zq short");
    // R8
    drv(1,0,0, 0,0,1, 3'd2, 0,0,0, 4'd11,0,2'd0,3'd0,0, "R8 self-refresh entry");
    drv(1,0,1, 0,0,0, 3'd2, 0,0,0, 4'd12,0,2'd0,3'd0,0, "R8 power-down deselect");
    drv(1,0,0, 1,1,1, 3'd2, 0,0,0, 4'd12,0,2'd0,3'd0,0, "R8 power-down nop");
    // R10
    drv(0,0,0, 0,0,0, 3'd5, 1,1,1, 4'd14,0,2'd0,3'd0,0, "R10 hold mrs pattern");
    drv(0,0,1, 1,0,1, 3'd1, 0,0,0, 4'd14,0,2'd0,3'd0,0, "R10 hold deselect");
    // R9
    drv(0,1,1, 0,0,0, 3'd3, 1,1,1, 4'd13,0,2'd0,3'd0,0, "R9 exit deselect");
    drv(0,1,0, 1,1,1, 3'd3, 1,1,1, 4'd13,0,2'd0,3'd0,0, "R9 exit nop");
    // R11
    drv(1,0,0, 0,1,1, 3'd3, 1,0,0, 4'd1,0,2'd0,3'd0,1, "R11 activate on entry");
    drv(0,1,0, 1,0,1, 3'd6, 1,1,1, 4'd1,0,2'd0,3'd0,1, "R11 read on exit");
    drv(1,0,0, 1,0,0, 3'd7, 1,1,1, 4'd1,0,2'd0,3'd0,1, "R11 write on entry");
    // R2 recovery: a legal command right after an illegal one
    drv(1,1,0, 0,0,0, 3'd1, 0,0,0, 4'd2,0,2'd0,3'd1,0, "R2 R3 mrs after illegal");
    drv(1,1,0, 1,0,1, 3'd6, 1,1,1, 4'd8,1,2'd2,3'd6,0, "R5 read before reset");

    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    // R1: asynchronous reset clears live outputs
    rst_n = 1'b0;
    #1;
    compare(pack_out(4'd0, 0, 2'd0, 3'd0, 0), "R1 reset mid-run");
    @(negedge clk);
    compare(pack_out(4'd0, 0, 2'd0, 3'd0, 0), "R1 reset held");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule